// File: doc/BRIEF.md
# Peripheral DMA Channel Controller

This block is the control side of one peripheral DMA channel. Software reaches it through a 32-bit register bus. The bus exposes five things:

- a command/status register (CSR);
- a current pointer;
- a limit pointer;
- start and stop pointers used for one automatic reload;
- an initial-buffer pointer.

The CSR is not a plain storage register. Each write is a set of one-shot commands: set-enable, set-update, set-direction, clear-complete and reset. Command bits written as 0 leave the flags alone.

While the channel is enabled, each device transfer strobe moves the current pointer forward by one 32-bit word. When the advanced pointer reaches the limit, the channel either stops or reloads once from start/stop:

- **It stops** when the update flag is clear. The enable flag drops and the complete flag rises.
- **It reloads** when the update flag is set. The pointers are reloaded from start/stop, the channel keeps running, the update flag clears and the complete flag rises.

The interrupt request follows the complete flag.

The channel sequencer has two states:

- **IDLE**: the channel is disabled.
- **RUN**: the channel is enabled.

Its transitions are:

- **START** (IDLE to RUN): a set-enable command without reset.
- **FINISH** (RUN to IDLE): terminal count with the update flag clear.
- **RELOAD** (RUN to RUN): terminal count with the update flag set.
- **ABORT** (RUN to IDLE): a reset command.

A set-enable command arriving in the same cycle as FINISH keeps the channel in RUN.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the CSR, all pointer registers and the size register read 0, and `irq` is low.
- R2: The current (0x4000), limit (0x4004), start (0x4008), stop (0x400C) and initial-buffer (0x4200) pointers are 32-bit read/write registers. Read data appears with `rd_valid` one cycle after the read request.
- R3: Only full-word accesses (`req_be` = 4'hF) take effect. A write with any other byte-enable changes nothing, and such a read returns 0.
- R4: A read of an undecoded offset returns 0, and a write to one changes no register.
- R5: A CSR (offset 0x0) write with bit0 set sets the enable flag, read back at bit24. Bit1 sets the update flag (bit25). Bit2 sets the device-to-memory direction flag (bit26). Writing 0 to these bits leaves the flags unchanged.
- R6: A CSR write with bit3 set clears only the complete flag (bit27).
- R7: A CSR write with bit4 set clears the complete, update, enable and direction flags. It overrides set commands in the same write.
- R8: While enabled, each `dev_strobe` adds 4 to the current pointer. A strobe while disabled has no effect.
- R9: When a strobe makes the current pointer equal to the limit with the update flag clear, the enable flag clears and the complete flag sets on that same edge. `irq` equals the complete flag and stays high until the flag is cleared by command.
- R10: When that terminal count occurs with the update flag set, the current and limit pointers load from start and stop. The channel stays enabled, the update flag clears and the complete flag sets.
- R11: Offset 0x4204 is read-only and returns limit minus current pointer (modulo 2^32).
- R12: A bus write to the current pointer in the same cycle as a strobe wins over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the channel |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| dev_strobe | input | 1 | Device transfer handshake, one word per cycle high |
| irq | output | 1 | Interrupt request, equal to the complete flag |

## Verification
Read data is due exactly one clock after the read request. The bench pushes the expected word into a queue in the cycle it issues the request, and a monitor pops and compares it on the falling edge after the next rising edge. Writes, commands and strobes take effect on the rising edge that samples them. So each read or `irq` check is placed after that edge and never in the same cycle as the stimulus. Terminal count and reload are checked by the flag pattern and pointer values read back on the cycles that follow.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    // Register offsets inside one channel window
    localparam int OFF_CSR   = 'h0000;
    localparam int OFF_NEXT  = 'h4000;
    localparam int OFF_LIMIT = 'h4004;
    localparam int OFF_START = 'h4008;
    localparam int OFF_STOP  = 'h400C;
    localparam int OFF_INIT  = 'h4200;
    localparam int OFF_SIZE  = 'h4204;

    // Command bit positions in a CSR write
    localparam int CMD_SET_EN   = 0;
    localparam int CMD_SET_UPD  = 1;
    localparam int CMD_SET_DIR  = 2;
    localparam int CMD_CLR_CMPL = 3;
    localparam int CMD_RESET    = 4;
    localparam int CMD_W        = 5;

    // Flag positions in a CSR read
    localparam int STS_EN   = 24;
    localparam int STS_UPD  = 25;
    localparam int STS_DIR  = 26;
    localparam int STS_CMPL = 27;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CSR,
        SEL_NEXT,
        SEL_LIMIT,
        SEL_PLAIN,
        SEL_SIZE
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_e;

    typedef struct packed {
        logic en;
        logic upd;
        logic dir;
        logic cmpl;
    } chan_flags_t;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NPLAIN  = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    output reg_sel_e                  sel,
    output logic [$clog2(NPLAIN)-1:0] plain_idx
);

    always_comb begin
        sel       = SEL_NONE;
        plain_idx = '0;
        unique case (addr)
            ADDR_W'(OFF_CSR):   sel = SEL_CSR;
            ADDR_W'(OFF_NEXT):  sel = SEL_NEXT;
            ADDR_W'(OFF_LIMIT): sel = SEL_LIMIT;
            ADDR_W'(OFF_START): begin
                sel       = SEL_PLAIN;
                plain_idx = ($clog2(NPLAIN))'(0);
            end
            ADDR_W'(OFF_STOP): begin
                sel       = SEL_PLAIN;
                plain_idx = ($clog2(NPLAIN))'(1);
            end
            ADDR_W'(OFF_INIT): begin
                sel       = SEL_PLAIN;
                plain_idx = ($clog2(NPLAIN))'(2);
            end
            ADDR_W'(OFF_SIZE):  sel = SEL_SIZE;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              strobe,
    input  logic              at_limit,
    output chan_flags_t       flags,
    output logic              advance,
    output logic              reload
);

    ch_state_e st_q, st_d;
    logic      upd_q, dir_q, cmpl_q;
    logic      c_en, c_upd, c_dir, c_clr, c_rst;
    logic      ev_finish, ev_reload;

    assign c_en  = csr_wr && cmd[CMD_SET_EN];
    assign c_upd = csr_wr && cmd[CMD_SET_UPD];
    assign c_dir = csr_wr && cmd[CMD_SET_DIR];
    assign c_clr = csr_wr && cmd[CMD_CLR_CMPL];
    assign c_rst = csr_wr && cmd[CMD_RESET];

    assign advance   = (st_q == CH_RUN) && strobe;
    assign ev_finish = advance && at_limit && !upd_q;
    assign ev_reload = advance && at_limit && upd_q;
    assign reload    = ev_reload;

    // Next-state logic: START, FINISH, RELOAD (self loop), ABORT
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (c_en && !c_rst) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (c_rst)                   st_d = CH_IDLE;
                else if (ev_finish && !c_en) st_d = CH_IDLE;
                else                         st_d = CH_RUN;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // Flag registers driven by commands and terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q  <= 1'b0;
            dir_q  <= 1'b0;
            cmpl_q <= 1'b0;
        end else if (c_rst) begin
            upd_q  <= 1'b0;
            dir_q  <= 1'b0;
            cmpl_q <= 1'b0;
        end else begin
            if (c_upd)          upd_q <= 1'b1;
            else if (ev_reload) upd_q <= 1'b0;
            if (c_dir)          dir_q <= 1'b1;
            if (c_clr)                       cmpl_q <= 1'b0;
            else if (ev_finish || ev_reload) cmpl_q <= 1'b1;
        end
    end

    assign flags.en   = (st_q == CH_RUN);
    assign flags.upd  = upd_q;
    assign flags.dir  = dir_q;
    assign flags.cmpl = cmpl_q;

endmodule

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPLAIN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  reg_sel_e                   sel,
    input  logic [$clog2(NPLAIN)-1:0]  plain_idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       advance,
    input  logic                       reload,
    output logic [DATA_W-1:0]          cur_ptr,
    output logic [DATA_W-1:0]          lim_ptr,
    output logic [DATA_W-1:0]          plain_rd,
    output logic [DATA_W-1:0]          remain,
    output logic                       at_limit
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    logic [DATA_W-1:0] nxt_q, lim_q;
    logic [DATA_W-1:0] plain_q [NPLAIN];
    logic [DATA_W-1:0] nxt_inc;

    assign nxt_inc = nxt_q + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n)                          nxt_q <= '0;
        else if (wr_en && sel == SEL_NEXT)   nxt_q <= wdata;
        else if (reload)                     nxt_q <= plain_q[0];
        else if (advance)                    nxt_q <= nxt_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          lim_q <= '0;
        else if (wr_en && sel == SEL_LIMIT)  lim_q <= wdata;
        else if (reload)                     lim_q <= plain_q[1];
    end

    // Start, stop and initial-buffer: plain storage
    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_q[g] <= '0;
            else if (wr_en && sel == SEL_PLAIN &&
                     plain_idx == ($clog2(NPLAIN))'(g))
                plain_q[g] <= wdata;
        end
    end

    assign cur_ptr  = nxt_q;
    assign lim_ptr  = lim_q;
    assign plain_rd = plain_q[plain_idx];
    assign remain   = lim_q - nxt_q;
    assign at_limit = (nxt_inc == lim_q);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dev_strobe,
    output logic              irq
);

    localparam int BE_W   = DATA_W / 8;
    localparam int NPLAIN = 3;
    localparam int IDX_W  = $clog2(NPLAIN);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  plain_idx;
    logic              full_word, wr_ok, rd_req;
    chan_flags_t       flags;
    logic              advance, reload, at_limit;
    logic [DATA_W-1:0] cur_ptr, lim_ptr, plain_rd, remain;
    logic [DATA_W-1:0] csr_rd, rd_mux;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    assign full_word = (req_be == {BE_W{1'b1}});
    assign wr_ok     = req_valid && req_write && full_word;
    assign rd_req    = req_valid && !req_write;

    dma_reg_decode #(.ADDR_W(ADDR_W), .NPLAIN(NPLAIN)) u_dec (
        .addr      (req_addr),
        .sel       (sel),
        .plain_idx (plain_idx)
    );

    dma_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (wr_ok && sel == SEL_CSR),
        .cmd      (req_wdata[CMD_W-1:0]),
        .strobe   (dev_strobe),
        .at_limit (at_limit),
        .flags    (flags),
        .advance  (advance),
        .reload   (reload)
    );

    dma_ptr_bank #(.DATA_W(DATA_W), .NPLAIN(NPLAIN)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .sel       (sel),
        .plain_idx (plain_idx),
        .wdata     (req_wdata),
        .advance   (advance),
        .reload    (reload),
        .cur_ptr   (cur_ptr),
        .lim_ptr   (lim_ptr),
        .plain_rd  (plain_rd),
        .remain    (remain),
        .at_limit  (at_limit)
    );

    always_comb begin
        csr_rd           = '0;
        csr_rd[STS_EN]   = flags.en;
        csr_rd[STS_UPD]  = flags.upd;
        csr_rd[STS_DIR]  = flags.dir;
        csr_rd[STS_CMPL] = flags.cmpl;
    end

    always_comb begin
        rd_mux = '0;
        if (full_word) begin
            unique case (sel)
                SEL_CSR:   rd_mux = csr_rd;
                SEL_NEXT:  rd_mux = cur_ptr;
                SEL_LIMIT: rd_mux = lim_ptr;
                SEL_PLAIN: rd_mux = plain_rd;
                SEL_SIZE:  rd_mux = remain;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_req;
            rd_data_q  <= rd_req ? rd_mux : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign irq      = flags.cmpl;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              dev_strobe,
    input logic              irq,
    input logic              en,
    input logic              upd,
    input logic              cmpl,
    input logic              csr_wr,
    input logic              rst_cmd,
    input logic [DATA_W-1:0] nxt,
    input logic [DATA_W-1:0] lim,
    input logic [DATA_W-1:0] sta,
    input logic [DATA_W-1:0] stp
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    logic wr_any;
    assign wr_any = req_valid && req_write;

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dev_strobe && !wr_any && (nxt + STEP != lim))
        |=> (nxt == $past(nxt) + STEP));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_any) |=> $stable(nxt));

    a_r9_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dev_strobe && !upd && !wr_any && (nxt + STEP == lim))
        |=> (!en && cmpl && irq));

    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_any) |=> irq);

    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dev_strobe && upd && !wr_any && (nxt + STEP == lim))
        |=> (en && !upd && cmpl && nxt == $past(sta) && lim == $past(stp)));

    a_r7_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && rst_cmd) |=> (!en && !upd && !cmpl && !irq));

endmodule

bind dma_chan_ctl dma_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .dev_strobe (dev_strobe),
    .irq        (irq),
    .en         (flags.en),
    .upd        (flags.upd),
    .cmpl       (flags.cmpl),
    .csr_wr     (wr_ok && sel == dma_chan_pkg::SEL_CSR),
    .rst_cmd    (req_wdata[dma_chan_pkg::CMD_RESET]),
    .nxt        (cur_ptr),
    .lim        (lim_ptr),
    .sta        (u_ptr.plain_q[0]),
    .stp        (u_ptr.plain_q[1])
);

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;

    localparam logic [31:0] F_EN   = 32'h0100_0000;
    localparam logic [31:0] F_UPD  = 32'h0200_0000;
    localparam logic [31:0] F_DIR  = 32'h0400_0000;
    localparam logic [31:0] F_CMPL = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        dev_strobe = 1'b0;
    logic        irq;

    int n_checks = 0, n_fails = 0;
    int m_checks = 0, m_fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    dma_chan_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dev_strobe(dev_strobe), .irq(irq)
    );

    // Monitor: compares each returned read against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            m_checks++;
            if (exp_q.size() == 0) begin
                m_fails++;
                $display("FAIL unexpected read data: actual=%h expected=none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (rd_data !== e) begin
                    m_fails++;
                    $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d,
                             input logic [3:0] be = 4'hF, input logic stb = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be;
        req_wdata = d; dev_strobe = stb;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; dev_strobe = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [31:0] e,
                            input string t, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dev_strobe = 1'b1;
            @(negedge clk);
            dev_strobe = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fails++;
            $display("FAIL %s irq: actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d",
                 n_checks + m_checks, n_fails + m_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1");
        bus_read(16'h0000, 32'h0, "R1 csr");
        bus_read(16'h4000, 32'h0, "R1 next");
        bus_read(16'h4004, 32'h0, "R1 limit");
        bus_read(16'h4204, 32'h0, "R1 size");

        // R2 pointer registers
        bus_write(16'h4000, 32'h0000_1000);
        bus_write(16'h4004, 32'h0000_1010);
        bus_write(16'h4008, 32'h0000_2000);
        bus_write(16'h400C, 32'h0000_2008);
        bus_write(16'h4200, 32'hABCD_0000);
        bus_read(16'h4000, 32'h0000_1000, "R2 next");
        bus_read(16'h4004, 32'h0000_1010, "R2 limit");
        bus_read(16'h4008, 32'h0000_2000, "R2 start");
        bus_read(16'h400C, 32'h0000_2008, "R2 stop");
        bus_read(16'h4200, 32'hABCD_0000, "R2 init");

        // R3 partial-width access
        bus_write(16'h4000, 32'h0000_5555, 4'h3);
        bus_read(16'h4000, 32'h0000_1000, "R3 partial write ignored");
        bus_read(16'h4004, 32'h0, "R3 partial read zero", 4'h1);
        bus_write(16'h0000, 32'h0000_0001, 4'h7);
        bus_read(16'h0000, 32'h0, "R3 partial csr write ignored");

        // R4 undecoded offsets
        bus_write(16'h0100, 32'hFFFF_FFFF);
        bus_read(16'h0100, 32'h0, "R4 undecoded read");
        bus_read(16'h4000, 32'h0000_1000, "R4 next untouched");

        // R11 size
        bus_read(16'h4204, 32'h0000_0010, "R11 size");

        // R8 strobe while disabled
        strobe(1);
        bus_read(16'h4000, 32'h0000_1000, "R8 idle strobe");

        // R5 set commands
        bus_write(16'h0000, 32'h0000_0004);
        bus_read(16'h0000, F_DIR, "R5 dir");
        bus_write(16'h0000, 32'h0000_0001);
        bus_read(16'h0000, F_DIR | F_EN, "R5 enable");
        bus_write(16'h0000, 32'h0000_0000);
        bus_read(16'h0000, F_DIR | F_EN, "R5 zero write keeps flags");

        // R8 advance
        strobe(1);
        bus_read(16'h4000, 32'h0000_1004, "R8 advance");
        bus_read(16'h4204, 32'h0000_000C, "R11 size after advance");

        // R9 terminal count
        strobe(3);
        bus_read(16'h4000, 32'h0000_1010, "R9 next at limit");
        bus_read(16'h0000, F_DIR | F_CMPL, "R9 finish flags");
        chk_irq(1'b1, "R9 raised");
        strobe(1);
        bus_read(16'h4000, 32'h0000_1010, "R8 no advance after finish");
        bus_write(16'h0000, 32'h0000_0000);
        chk_irq(1'b1, "R9 hold");

        // R6 clear complete
        bus_write(16'h0000, 32'h0000_0008);
        bus_read(16'h0000, F_DIR, "R6 clear complete only");
        chk_irq(1'b0, "R6");

        // R10 reload
        bus_write(16'h4000, 32'h0000_1000);
        bus_write(16'h4004, 32'h0000_1008);
        bus_write(16'h0000, 32'h0000_0003);
        bus_read(16'h0000, F_EN | F_UPD | F_DIR, "R5 enable+update");
        strobe(2);
        bus_read(16'h4000, 32'h0000_2000, "R10 next from start");
        bus_read(16'h4004, 32'h0000_2008, "R10 limit from stop");
        bus_read(16'h0000, F_EN | F_DIR | F_CMPL, "R10 flags");
        chk_irq(1'b1, "R10");
        strobe(2);
        bus_read(16'h0000, F_DIR | F_CMPL, "R9 finish after reload");
        bus_read(16'h4000, 32'h0000_2008, "R9 next after second pass");

        // R7 reset command overrides sets
        bus_write(16'h0000, 32'h0000_0013);
        bus_read(16'h0000, 32'h0, "R7 reset");
        chk_irq(1'b0, "R7");

        // R12 write beats strobe
        bus_write(16'h0000, 32'h0000_0001);
        bus_write(16'h4000, 32'h0000_3000, 4'hF, 1'b1);
        bus_read(16'h4000, 32'h0000_3000, "R12 write wins");
        bus_write(16'h0000, 32'h0000_0010);

        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule